// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block is the digital side of one microcontroller I/O port. It holds the port output latch and accepts two kinds of register-bus writes: whole-byte loads, and single-bit set or clear by index. A read returns either the latch or the synchronized pin levels. Read-modify-write sequences use the latch view, so pins that are pulled low from outside do not corrupt the stored value. For each pin, three pad controls are produced: a pull-low enable, a strong pullup enable and a weak pullup enable.

A build-time kind selects between two pad behaviours. In quasi-bidirectional ports the weak pullup is always on. Each pin whose latch bit rises from 0 to 1 gets a strong pullup for exactly `PULSE_CYCLES` clocks (two by default). In open-drain ports no pullup is used for plain output. Such a port can be handed to an external-memory bus instead: the bus value then drives the pins, and the pullup is enabled only on pins where the bus drives a 1. The reset value of the latch is a parameter, so the same block serves ports that come up high and ports that come up low.

Top module: `qb_port_ctrl`

## Requirements
- R1: While `rst_ni` is low, the latch equals `RESET_VAL` (asynchronously), the pin synchronizer holds zeros and no strong pullup is enabled.
- R2: A byte write (`wr_byte_i`=1) loads `wr_data_i` into the latch at the rising clock edge.
- R3: A bit write (`wr_bit_i`=1) sets bit `bit_idx_i` of the latch to `bit_val_i` and leaves the other bits unchanged. If a byte write occurs in the same cycle, the byte is loaded first and the bit write is applied on top of it.
- R4: `rd_data_o` returns the latch when `rd_pin_i`=0 and the synchronized pin levels when `rd_pin_i`=1. The selection is combinational.
- R5: A change on `pin_i` passes through two flops. It appears on the pin read after the second rising edge, and not after the first.
- R6: `pull_low_o[i]` is 1 exactly when the effective output of pin i is 0. The effective output is the latch bit, or `bus_data_i[i]` when an open-drain port is in bus mode.
- R7: In a quasi-bidirectional port, `weak_pu_o` is all ones at all times, including during reset.
- R8: In a quasi-bidirectional port, a 0-to-1 change of latch bit i asserts `strong_pu_o[i]` for exactly `PULSE_CYCLES` clock cycles, starting in the cycle after the writing edge.
- R9: A 1-to-0 change of a latch bit ends its strong pullup at the same edge that clears the bit.
- R10: In a quasi-bidirectional port, `bus_mode_i` and `bus_data_i` have no effect on any output.
- R11: In an open-drain port outside bus mode, `strong_pu_o` and `weak_pu_o` are all zeros. Writing 1 releases the pin, so `pull_low_o` is 0 for that pin.
- R12: In an open-drain port in bus mode, `strong_pu_o` equals `bus_data_i` combinationally, `weak_pu_o` stays zero, and the latch is not changed.
- R13: The reset value of the latch produces no strong pullup pulse when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_byte_i | input | 1 | Byte write strobe |
| wr_data_i | input | PORT_W | Byte write data |
| wr_bit_i | input | 1 | Bit write strobe |
| bit_idx_i | input | IDX_W | Index of the bit to write |
| bit_val_i | input | 1 | Value for the bit write |
| rd_pin_i | input | 1 | Read select: 1 selects pins, 0 selects latch |
| rd_data_o | output | PORT_W | Read data |
| pin_i | input | PORT_W | Pad input levels |
| bus_mode_i | input | 1 | External-memory bus owns the port (open-drain kind only) |
| bus_data_i | input | PORT_W | Bus address/data to drive |
| pull_low_o | output | PORT_W | Pull-low driver enable per pin |
| strong_pu_o | output | PORT_W | Strong pullup enable per pin |
| weak_pu_o | output | PORT_W | Weak pullup enable per pin |

## Verification
The bound checker enforces, in every cycle, the relations between outputs and latch state. Strong pullup and pull-low are never on together. A latch rise always starts a strong pulse, and no pulse ever lasts longer than `PULSE_CYCLES`. A bit write leaves the other latch bits unchanged, and the open-drain pullup rules hold in and out of bus mode. Other behaviours can only be shown by the bench's scenarios: that a pulse lasts exactly two cycles and not fewer, that the pulse is cancelled when a bit is set and then cleared, that the two-stage pin latency holds, that a byte write and a bit write in the same cycle combine correctly, and that bus inputs are ignored by a quasi-bidirectional port.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;
  typedef enum logic {
    PORT_QUASI      = 1'b0,
    PORT_OPEN_DRAIN = 1'b1
  } port_kind_e;
endpackage

// File: rtl/qb_port_latch.sv
module qb_port_latch #(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] RESET_VAL = '1,
  localparam int IDX_W = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_byte_i,
  input  logic [PORT_W-1:0] wr_data_i,
  input  logic              wr_bit_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  output logic [PORT_W-1:0] latch_d_o,
  output logic [PORT_W-1:0] latch_q_o
);
  logic [PORT_W-1:0] latch_q;

  // byte load first, bit write applied on top
  always_comb begin
    latch_d_o = latch_q;
    if (wr_byte_i) latch_d_o = wr_data_i;
    if (wr_bit_i && (int'(bit_idx_i) < PORT_W)) latch_d_o[bit_idx_i] = bit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= RESET_VAL;
    else         latch_q <= latch_d_o;
  end

  assign latch_q_o = latch_q;
endmodule

// File: rtl/qb_pin_sync.sv
module qb_pin_sync #(
  parameter int PORT_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o
);
  logic [PORT_W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pin_i;
      else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/qb_pu_pulse.sv
module qb_pu_pulse #(
  parameter int PORT_W       = 8,
  parameter int PULSE_CYCLES = 2,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] latch_d_i,
  input  logic [PORT_W-1:0] latch_q_i,
  output logic [PORT_W-1:0] strong_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= '0;
      else if (!latch_d_i[i])       cnt_q <= '0;     // falling bit cancels
      else if (!latch_q_i[i])       cnt_q <= LOAD;   // rising bit starts
      else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
    end

    assign strong_o[i] = (cnt_q != '0);
  end
endmodule

// File: rtl/qb_pad_drive.sv
module qb_pad_drive
  import qb_port_pkg::*;
#(
  parameter int         PORT_W = 8,
  parameter port_kind_e KIND   = PORT_QUASI
) (
  input  logic [PORT_W-1:0] latch_q_i,
  input  logic              bus_mode_i,
  input  logic [PORT_W-1:0] bus_data_i,
  input  logic [PORT_W-1:0] pulse_i,
  output logic [PORT_W-1:0] pull_low_o,
  output logic [PORT_W-1:0] strong_pu_o,
  output logic [PORT_W-1:0] weak_pu_o
);
  localparam bit IS_OD = (KIND == PORT_OPEN_DRAIN);

  logic              bus_own;
  logic [PORT_W-1:0] eff;

  assign bus_own     = IS_OD && bus_mode_i;
  assign eff         = bus_own ? bus_data_i : latch_q_i;
  assign pull_low_o  = ~eff;
  assign strong_pu_o = IS_OD ? (bus_own ? bus_data_i : '0) : pulse_i;
  assign weak_pu_o   = IS_OD ? '0 : '1;
endmodule

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl
  import qb_port_pkg::*;
#(
  parameter int                PORT_W       = 8,
  parameter port_kind_e        KIND         = PORT_QUASI,
  parameter logic [PORT_W-1:0] RESET_VAL    = '1,
  parameter int                PULSE_CYCLES = 2,
  parameter int                SYNC_STAGES  = 2,
  localparam int IDX_W = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_byte_i,
  input  logic [PORT_W-1:0] wr_data_i,
  input  logic              wr_bit_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  input  logic              rd_pin_i,
  output logic [PORT_W-1:0] rd_data_o,
  input  logic [PORT_W-1:0] pin_i,
  input  logic              bus_mode_i,
  input  logic [PORT_W-1:0] bus_data_i,
  output logic [PORT_W-1:0] pull_low_o,
  output logic [PORT_W-1:0] strong_pu_o,
  output logic [PORT_W-1:0] weak_pu_o
);
  logic [PORT_W-1:0] latch_d, latch_q, pin_sync, pulse;

  qb_port_latch #(.PORT_W(PORT_W), .RESET_VAL(RESET_VAL)) u_latch (
    .clk_i, .rst_ni, .wr_byte_i, .wr_data_i, .wr_bit_i, .bit_idx_i, .bit_val_i,
    .latch_d_o(latch_d), .latch_q_o(latch_q)
  );

  qb_pin_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .pin_o(pin_sync)
  );

  if (KIND == PORT_QUASI) begin : g_quasi
    qb_pu_pulse #(.PORT_W(PORT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk_i, .rst_ni, .latch_d_i(latch_d), .latch_q_i(latch_q), .strong_o(pulse)
    );
  end else begin : g_od
    assign pulse = '0;
  end

  qb_pad_drive #(.PORT_W(PORT_W), .KIND(KIND)) u_pad (
    .latch_q_i(latch_q), .bus_mode_i, .bus_data_i, .pulse_i(pulse),
    .pull_low_o, .strong_pu_o, .weak_pu_o
  );

  assign rd_data_o = rd_pin_i ? pin_sync : latch_q;
endmodule

// File: rtl/qb_port_ctrl_chk.sv
module qb_port_ctrl_chk
  import qb_port_pkg::*;
#(
  parameter int         PORT_W       = 8,
  parameter port_kind_e KIND         = PORT_QUASI,
  parameter int         PULSE_CYCLES = 2,
  localparam int IDX_W = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_byte_i,
  input logic              wr_bit_i,
  input logic [IDX_W-1:0]  bit_idx_i,
  input logic              bus_mode_i,
  input logic [PORT_W-1:0] bus_data_i,
  input logic [PORT_W-1:0] latch_q,
  input logic [PORT_W-1:0] pull_low_o,
  input logic [PORT_W-1:0] strong_pu_o,
  input logic [PORT_W-1:0] weak_pu_o
);
  localparam bit IS_OD = (KIND == PORT_OPEN_DRAIN);

  assert_no_fight_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strong_pu_o & pull_low_o) == '0);

  assert_bit_isolate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bit_i && !wr_byte_i) |=>
      ((latch_q ^ $past(latch_q)) & ~(PORT_W'(1) << $past(bit_idx_i))) == '0);

  if (!IS_OD) begin : g_quasi_chk
    assert_weak_on_R7: assert property (@(posedge clk_i) weak_pu_o == '1);

    assert_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pull_low_o == ~latch_q);

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
      logic [7:0] run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              run_q <= '0;
        else if (!strong_pu_o[i]) run_q <= '0;
        else if (run_q != 8'hFF)  run_q <= run_q + 8'd1;
      end

      assert_pulse_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(latch_q[i]) |-> strong_pu_o[i]);

      assert_pulse_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(run_q) <= PULSE_CYCLES);

      assert_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !latch_q[i] |-> !strong_pu_o[i]);
    end
  end else begin : g_od_chk
    assert_od_plain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_mode_i |-> (strong_pu_o == '0 && weak_pu_o == '0));

    assert_od_bus_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_mode_i |-> (strong_pu_o == bus_data_i && pull_low_o == ~bus_data_i));

    assert_od_latch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_mode_i && !wr_byte_i && !wr_bit_i) |=> $stable(latch_q));
  end
endmodule

bind qb_port_ctrl qb_port_ctrl_chk #(
  .PORT_W(PORT_W), .KIND(KIND), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_byte_i(wr_byte_i), .wr_bit_i(wr_bit_i),
  .bit_idx_i(bit_idx_i), .bus_mode_i(bus_mode_i), .bus_data_i(bus_data_i),
  .latch_q(latch_q), .pull_low_o(pull_low_o), .strong_pu_o(strong_pu_o),
  .weak_pu_o(weak_pu_o)
);

// File: tb/qb_port_ctrl_bench.sv
`timescale 1ns/1ps
module qb_port_ctrl_bench;
  import qb_port_pkg::*;

  localparam int W = 8;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_byte = 1'b0, wr_bit = 1'b0, bit_val = 1'b0, rd_pin = 1'b0, bus_mode = 1'b0;
  logic [2:0]   bit_idx = '0;
  logic [W-1:0] wr_data = '0, pin = '0, bus_data = '0;
  logic [W-1:0] a_rd, a_pl, a_st, a_wk, b_rd, b_pl, b_st, b_wk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t q[$];
  event chk_ev;

  always #2 clk = ~clk;

  qb_port_ctrl #(.PORT_W(W), .KIND(PORT_QUASI), .RESET_VAL(8'hFF)) u_qb_port_ctrl (
    .clk_i(clk), .rst_ni, .wr_byte_i(wr_byte), .wr_data_i(wr_data), .wr_bit_i(wr_bit),
    .bit_idx_i(bit_idx), .bit_val_i(bit_val), .rd_pin_i(rd_pin), .rd_data_o(a_rd),
    .pin_i(pin), .bus_mode_i(bus_mode), .bus_data_i(bus_data),
    .pull_low_o(a_pl), .strong_pu_o(a_st), .weak_pu_o(a_wk)
  );

  qb_port_ctrl #(.PORT_W(W), .KIND(PORT_OPEN_DRAIN), .RESET_VAL(8'h00)) u_qb_port_ctrl_od (
    .clk_i(clk), .rst_ni, .wr_byte_i(wr_byte), .wr_data_i(wr_data), .wr_bit_i(wr_bit),
    .bit_idx_i(bit_idx), .bit_val_i(bit_val), .rd_pin_i(rd_pin), .rd_data_o(b_rd),
    .pin_i(pin), .bus_mode_i(bus_mode), .bus_data_i(bus_data),
    .pull_low_o(b_pl), .strong_pu_o(b_st), .weak_pu_o(b_wk)
  );

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return a_rd;  1: return a_pl;  2: return a_st;  3: return a_wk;
      4: return b_rd;  5: return b_pl;  6: return b_st;  default: return b_wk;
    endcase
  endfunction

  // monitor: pops expectations and compares against live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #0.1;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic byte_wr(logic [7:0] d);
    wr_byte = 1'b1; wr_data = d; cyc(); wr_byte = 1'b0;
  endtask

  task automatic bit_wr(int idx, logic v);
    wr_bit = 1'b1; bit_idx = 3'(idx); bit_val = v; cyc(); wr_bit = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    // R1 R7 R11: reset state of both kinds
    expect_val("R1", 0, 8'hFF); expect_val("R1", 2, 8'h00); expect_val("R6", 1, 8'h00);
    expect_val("R7", 3, 8'hFF); expect_val("R1", 4, 8'h00); expect_val("R6", 5, 8'hFF);
    expect_val("R11", 6, 8'h00); expect_val("R11", 7, 8'h00);
    flush();

    rst_ni = 1'b1;
    cyc(); cyc();
    expect_val("R13", 2, 8'h00); expect_val("R13", 0, 8'hFF); flush();

    byte_wr(8'h5A);
    expect_val("R2", 0, 8'h5A); expect_val("R6", 1, 8'hA5); expect_val("R8", 2, 8'h00);
    expect_val("R2", 4, 8'h5A); expect_val("R11", 6, 8'h00); expect_val("R11", 7, 8'h00);
    flush();

    byte_wr(8'hFF);
    expect_val("R8", 2, 8'hA5); expect_val("R2", 0, 8'hFF); expect_val("R11", 6, 8'h00);
    flush();
    cyc(); expect_val("R8", 2, 8'hA5); expect_val("R7", 3, 8'hFF); flush();
    cyc(); expect_val("R8", 2, 8'h00); flush();

    bit_wr(3, 1'b0);
    expect_val("R3", 0, 8'hF7); expect_val("R9", 2, 8'h00); expect_val("R6", 1, 8'h08);
    flush();
    bit_wr(3, 1'b1);
    expect_val("R3", 0, 8'hFF); expect_val("R8", 2, 8'h08); flush();
    cyc(); expect_val("R8", 2, 8'h08); flush();
    cyc(); expect_val("R8", 2, 8'h00); flush();

    // R9: cancel after one pulse cycle
    bit_wr(3, 1'b0);
    bit_wr(3, 1'b1);
    expect_val("R8", 2, 8'h08); flush();
    bit_wr(3, 1'b0);
    expect_val("R9", 2, 8'h00); expect_val("R9", 0, 8'hF7); expect_val("R6", 1, 8'h08);
    flush();
    cyc(); expect_val("R9", 2, 8'h00); flush();

    // R3: byte and bit write in the same cycle
    wr_bit = 1'b1; bit_idx = 3'd7; bit_val = 1'b1;
    byte_wr(8'h00);
    wr_bit = 1'b0;
    expect_val("R3", 0, 8'h80); expect_val("R8", 2, 8'h00); expect_val("R3", 4, 8'h80);
    flush();

    // R4 R5: pin path latency
    pin = 8'h3C; rd_pin = 1'b1;
    cyc(); expect_val("R5", 0, 8'h00); flush();
    cyc(); expect_val("R5", 0, 8'h3C); expect_val("R4", 4, 8'h3C); flush();
    rd_pin = 1'b0; #1;
    expect_val("R4", 0, 8'h80); flush();

    // R10 R12: bus mode
    bus_mode = 1'b1; bus_data = 8'hC3; #1;
    expect_val("R10", 1, 8'h7F); expect_val("R10", 2, 8'h00); expect_val("R10", 3, 8'hFF);
    expect_val("R12", 5, 8'h3C); expect_val("R12", 6, 8'hC3); expect_val("R12", 7, 8'h00);
    flush();
    cyc(); cyc();
    expect_val("R12", 4, 8'h80); expect_val("R10", 0, 8'h80); expect_val("R10", 2, 8'h00);
    flush();
    bus_mode = 1'b0; #1;
    expect_val("R11", 5, 8'h7F); expect_val("R11", 6, 8'h00); flush();

    byte_wr(8'hFF);
    expect_val("R11", 5, 8'h00); expect_val("R11", 6, 8'h00); expect_val("R11", 7, 8'h00);
    flush();

    cyc();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule